// File: doc/BRIEF.md
# Cascaded-Divider Peripheral Clock Generator

This block derives one peripheral clock from three reference clocks: the I/O reference, the CPU reference and the memory reference. A source multiplexer picks one reference. Two 6-bit dividers in series then slow it down. A bypass select can replace the divided clock with an external clock, and up to two gates drive the outputs. Every clock is modelled as a single-cycle enable pulse in the one system clock domain. The reference and external inputs are pulses, and so are the outputs.

Software sets up the block through a single 32-bit control word on a plain write/read port. A build option moves the gate into a second word at byte offset 8, where the gate bit works the other way round (1 means stopped). Changes to the source, the divisors or the bypass are held back until the divide period in progress has finished, so no output period is ever shortened. The gates act at once, and the divider chain keeps counting while the outputs are gated.

Top module: `pclk_divgen`

## Requirements
- R1: After reset the control word reads 0 and both enable outputs are low.
- R2: The control word at byte offset 0 reads back the last value written with the unused bits cleared. The writable bits are 25:20, 13:8 and 6:4. Bits 1:0 are also writable in the two-gate build and bit 0 alone in the one-gate build; in the separate-gate build neither is writable. Any other offset reads 0, except the gate word of R8.
- R3: The 2-bit source code in bits 5:4 picks the reference. Codes 0 and 1 both select refTick[0] (I/O), code 2 selects refTick[1] (CPU) and code 3 selects refTick[2] (memory).
- R4: The first divisor in bits 13:8 counts source pulses one-based, so N gives one pulse per N source pulses. A value of 0 divides by one.
- R5: The second divisor in bits 25:20 divides the output of the first, with the same one-based rule and the same treatment of 0. The output period is therefore the product of the two effective divisors, counted in source pulses.
- R6: Bit 6 set to 1 routes extTick to the gates in place of the divided clock.
- R7: Bit 0 gates output 0 and bit 1 gates output 1, and both outputs are fed from the same divided clock. A gate change applies from the next output cycle.
- R8: In the separate-gate build, output 0 is gated by bit 0 of the word at byte offset 8, where 1 stops the clock. That bit reads back there and resets to 1.
- R9: A new source, divisor or bypass value takes effect only when the divide period in progress completes, or at once if the chain is at a period boundary with no source pulse present.
- R10: While an output is gated off, the divider chain keeps counting, so pulses resume in their former phase when the gate is re-enabled.
- R11: An output pulse appears in the cycle after the source or external pulse that ends a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refTick | input | 3 | Reference enable pulses: bit 0 I/O, bit 1 CPU, bit 2 memory |
| extTick | input | 1 | External clock enable pulse |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| clkEn | output | 2 | Gated output clock enables |

## Verification
The hardest case to reach is a reconfiguration that lands in the middle of a long divide period. The bench waits for a known output pulse and writes the new divisor a few cycles into the following period. It then measures the spacing of the next two pulses: the first must still show the old period and the second the new one. Phase continuity across gating is checked the same way. The bench turns a gate off for a span that is not a multiple of the period, turns it back on, and requires every pulse to keep its original phase. A behavioural model built from counters follows every cycle.

// File: rtl/pclk_divgen_pkg.sv
`timescale 1ns/1ps
package pclk_divgen_pkg;

  localparam int RegW    = 32;
  localparam int DivW    = 6;
  localparam int NumRef  = 3;
  localparam int NumGate = 2;
  localparam int NumStg  = 2;

  // field positions inside the control word
  localparam int SelLsb  = 4;
  localparam int ExtBit  = 6;
  localparam int Div0Lsb = 8;
  localparam int Div1Lsb = 20;

  localparam logic [RegW-1:0] DivFieldOnes = RegW'((1 << DivW) - 1);
  localparam logic [RegW-1:0] PathMask =
      (DivFieldOnes << Div1Lsb) | (DivFieldOnes << Div0Lsb) |
      (RegW'(1) << ExtBit) | (RegW'(3) << SelLsb);

  typedef struct packed {
    logic [1:0]      srcSel;
    logic            extSel;
    logic [DivW-1:0] div0;
    logic [DivW-1:0] div1;
  } path_cfg_t;

  typedef struct packed {
    path_cfg_t            cfg;
    logic [NumGate-1:0]   gateOn;
  } ctl_strobe_t;

  typedef struct packed {
    logic periodEnd;
    logic cfgSlot;
  } dp_status_t;

  function automatic path_cfg_t decodeCtrl(input logic [RegW-1:0] w);
    path_cfg_t c;
    c.srcSel = w[SelLsb +: 2];
    c.extSel = w[ExtBit];
    c.div0   = w[Div0Lsb +: DivW];
    c.div1   = w[Div1Lsb +: DivW];
    return c;
  endfunction

  // source codes 0 and 1 share the first reference
  function automatic logic [1:0] refIndex(input logic [1:0] sel);
    return (sel < 2'd2) ? 2'd0 : (sel - 2'd1);
  endfunction

endpackage

// File: rtl/pclk_div_stage.sv
`timescale 1ns/1ps
module pclk_div_stage
  import pclk_divgen_pkg::*;
#(
  parameter int W = DivW
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickIn,
  input  logic [W-1:0] divisor,
  output logic         tickOut,
  output logic         atZero
);

  logic [W-1:0] cnt;
  logic [W-1:0] limit;
  logic         term;

  // one-based divisor, zero behaves as one
  assign limit   = (divisor == '0) ? '0 : (divisor - W'(1));
  assign term    = (cnt == limit);
  assign tickOut = tickIn & term;
  assign atZero  = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (tickIn) begin
      cnt <= term ? '0 : (cnt + W'(1));
    end
  end

endmodule

// File: rtl/pclk_dp.sv
`timescale 1ns/1ps
module pclk_dp
  import pclk_divgen_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumRef-1:0]  refTick,
  input  logic               extTick,
  input  ctl_strobe_t        ctl,
  output logic [NumGate-1:0] clkEn,
  output dp_status_t         stat
);

  logic                srcTick;
  logic [NumStg:0]     chainTick;
  logic [NumStg-1:0]   zeroVec;
  logic [DivW-1:0]     divs [NumStg];
  logic                pathTick;

  assign srcTick      = refTick[refIndex(ctl.cfg.srcSel)];
  assign chainTick[0] = srcTick;
  assign divs[0]      = ctl.cfg.div0;
  assign divs[1]      = ctl.cfg.div1;

  for (genvar s = 0; s < NumStg; s++) begin : g_stage
    pclk_div_stage #(.W(DivW)) u_stage (
      .clk     (clk),
      .rstN    (rstN),
      .tickIn  (chainTick[s]),
      .divisor (divs[s]),
      .tickOut (chainTick[s+1]),
      .atZero  (zeroVec[s])
    );
  end

  assign stat.periodEnd = chainTick[NumStg];
  // a new setting may load at a period end, or while parked at a boundary
  assign stat.cfgSlot   = chainTick[NumStg] | ((&zeroVec) & ~srcTick);

  assign pathTick = ctl.cfg.extSel ? extTick : chainTick[NumStg];

  for (genvar g = 0; g < NumGate; g++) begin : g_gate
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clkEn[g] <= 1'b0;
      end else begin
        clkEn[g] <= ctl.gateOn[g] & pathTick;
      end
    end
  end

endmodule

// File: rtl/pclk_ctl.sv
`timescale 1ns/1ps
module pclk_ctl
  import pclk_divgen_pkg::*;
#(
  parameter bit TWO_OUT     = 1'b1,
  parameter bit FABRIC_GATE = 1'b0,
  parameter int ADDR_W      = 8,
  parameter int GATE_OFS    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [RegW-1:0]   regWdata,
  output logic [RegW-1:0]   regRdata,
  input  dp_status_t        stat,
  output ctl_strobe_t       ctl
);

  localparam logic [RegW-1:0] GateMask =
      FABRIC_GATE ? '0 : (TWO_OUT ? RegW'(3) : RegW'(1));
  localparam logic [RegW-1:0] CtrlMask = PathMask | GateMask;

  logic [RegW-1:0]    ctrlQ;
  path_cfg_t          activeQ;
  logic               ctrlHit;
  logic               atGate;
  logic [NumGate-1:0] gateVec;
  logic [RegW-1:0]    gateRd;

  assign ctrlHit = regWr && (regAddr == ADDR_W'(0));
  assign atGate  = (regAddr == ADDR_W'(GATE_OFS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      activeQ <= '0;
    end else begin
      if (stat.cfgSlot) begin
        activeQ <= decodeCtrl(ctrlQ);
      end
      if (ctrlHit) begin
        ctrlQ <= regWdata & CtrlMask;
      end
    end
  end

  if (FABRIC_GATE) begin : g_fab
    logic gateOffQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gateOffQ <= 1'b1;
      end else if (regWr && atGate) begin
        gateOffQ <= regWdata[0];
      end
    end
    assign gateVec = {1'b0, ~gateOffQ};
    assign gateRd  = {{(RegW-1){1'b0}}, gateOffQ};
  end else begin : g_inline
    assign gateVec = ctrlQ[NumGate-1:0];
    assign gateRd  = '0;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(0)) begin
      regRdata = ctrlQ;
    end else if (FABRIC_GATE && atGate) begin
      regRdata = gateRd;
    end
  end

  assign ctl.cfg    = activeQ;
  assign ctl.gateOn = gateVec;

endmodule

// File: rtl/pclk_divgen.sv
`timescale 1ns/1ps
module pclk_divgen
  import pclk_divgen_pkg::*;
#(
  parameter bit TWO_OUT     = 1'b1,
  parameter bit FABRIC_GATE = 1'b0,
  parameter int ADDR_W      = 8,
  parameter int GATE_OFS    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        refTick,
  input  logic              extTick,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [1:0]        clkEn
);

  ctl_strobe_t ctlS;
  dp_status_t  dpStat;

  pclk_ctl #(
    .TWO_OUT     (TWO_OUT),
    .FABRIC_GATE (FABRIC_GATE),
    .ADDR_W      (ADDR_W),
    .GATE_OFS    (GATE_OFS)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .stat     (dpStat),
    .ctl      (ctlS)
  );

  pclk_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .extTick (extTick),
    .ctl     (ctlS),
    .clkEn   (clkEn),
    .stat    (dpStat)
  );

endmodule

// File: rtl/pclk_divgen_chk.sv
`timescale 1ns/1ps
module pclk_divgen_chk
  import pclk_divgen_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              extTick,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regRdata,
  input logic [1:0]        clkEn,
  input ctl_strobe_t       ctl,
  input dp_status_t        stat
);

  // R2: unused control bits never read back as 1
  p_rd_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(0)) |-> ((regRdata & 32'hFC0F_C080) == 32'h0));

  // R7: a closed gate keeps its output low in the next cycle
  p_gate0_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.gateOn[0] |=> !clkEn[0]);
  p_gate1_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.gateOn[1] |=> !clkEn[1]);

  // R6: bypass forwards the external pulse
  p_ext_path_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.cfg.extSel && ctl.gateOn[0]) |=> (clkEn[0] == $past(extTick)));

  // R11: internal path output follows the period end by one cycle
  p_int_path_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.cfg.extSel && ctl.gateOn[0]) |=> (clkEn[0] == $past(stat.periodEnd)));

  // R9: active setting only moves in a load slot
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stat.cfgSlot |=> $stable(ctl.cfg));

  // R5: back-to-back period ends only with both effective divisors at one
  p_div_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    stat.periodEnd |=> (!stat.periodEnd ||
                        (ctl.cfg.div0 <= 6'd1 && ctl.cfg.div1 <= 6'd1)));

endmodule

bind pclk_divgen pclk_divgen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .extTick  (extTick),
  .regAddr  (regAddr),
  .regRdata (regRdata),
  .clkEn    (clkEn),
  .ctl      (ctlS),
  .stat     (dpStat)
);

// File: tb/pclk_divgen_bench.sv
`timescale 1ns/1ps
module pclk_divgen_bench;

  localparam logic [31:0] MaskMain = 32'h03F0_3F73;
  localparam logic [31:0] MaskFab  = 32'h03F0_3F70;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  refTick = '0;
  logic        extTick = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata, fabRdata;
  logic [1:0]  clkEn, fabEn;

  int chkCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  bit done = 0;
  int pulseQ[$];

  // reference model state
  bit [31:0] mCtrl;
  int  mSel, mD0, mD1;
  bit  mExt;
  int  mC0, mC1;
  bit [1:0] expEn;

  always #2.5 clk = ~clk;

  pclk_divgen u_pclk_divgen (
    .clk(clk), .rstN(rstN), .refTick(refTick), .extTick(extTick),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .clkEn(clkEn)
  );

  pclk_divgen #(.TWO_OUT(1'b0), .FABRIC_GATE(1'b1)) u_pclk_divgen_fab (
    .clk(clk), .rstN(rstN), .refTick(refTick), .extTick(extTick),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(fabRdata), .clkEn(fabEn)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    chkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference pulse patterns: I/O every cycle, CPU every 2nd, memory every 3rd, external every 5th
  initial begin
    forever begin
      @(negedge clk);
      #1;
      cyc++;
      refTick[0] = 1'b1;
      refTick[1] = (cyc % 2) == 0;
      refTick[2] = (cyc % 3) == 0;
      extTick    = (cyc % 5) == 0;
    end
  end

  // behavioural model, advanced once per rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = '0; mSel = 0; mD0 = 0; mD1 = 0; mExt = 0;
      mC0 = 0; mC1 = 0; expEn = '0;
    end else begin
      int  src;
      int  e0, e1;
      bit  st, idle, t0, dt, path;
      src  = (mSel < 2) ? 0 : mSel - 1;
      st   = refTick[src];
      e0   = (mD0 == 0) ? 1 : mD0;
      e1   = (mD1 == 0) ? 1 : mD1;
      idle = (mC0 == 0) && (mC1 == 0) && !st;
      t0 = 0; dt = 0;
      if (st) begin
        mC0++;
        if (mC0 == e0) begin mC0 = 0; t0 = 1; end
      end
      if (t0) begin
        mC1++;
        if (mC1 == e1) begin mC1 = 0; dt = 1; end
      end
      path = mExt ? extTick : dt;
      expEn[0] = mCtrl[0] & path;
      expEn[1] = mCtrl[1] & path;
      if (dt || idle) begin
        mSel = int'(mCtrl[5:4]);
        mExt = mCtrl[6];
        mD0  = int'(mCtrl[13:8]);
        mD1  = int'(mCtrl[25:20]);
      end
      if (regWr && regAddr == 8'd0) mCtrl = regWdata & MaskMain;
    end
  end

  // per-cycle comparison against the model, plus pulse log
  always @(negedge clk) begin
    if (rstN) begin
      chk("R11 outputs vs model", clkEn, expEn);
      chk("R2 readback vs model", regRdata, (regAddr == 8'd0) ? mCtrl : 32'h0);
      if (clkEn[0]) pulseQ.push_back(cyc);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); #1;
    regWr = 1'b0; regAddr = 8'd0; regWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] dm, output logic [31:0] df);
    @(negedge clk); #1;
    regAddr = a;
    @(negedge clk);
    dm = regRdata; df = fabRdata;
    #1 regAddr = 8'd0;
  endtask

  task automatic countPulses(input int n, output int n0, output int n1, output int nf);
    n0 = 0; n1 = 0; nf = 0;
    repeat (n) begin
      @(negedge clk);
      n0 += int'(clkEn[0]);
      n1 += int'(clkEn[1]);
      nf += int'(fabEn[0]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chkCnt++; failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    int a, b, f;
    logic [31:0] dm, df;
    int expSrc[4] = '{60, 60, 30, 20};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ctrl after reset", regRdata, 0);
    chk("R1 outputs in reset", clkEn, 0);
    @(negedge clk); #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 outputs after reset", clkEn, 0);
    rd(8'd8, dm, df);
    chk("R8 gate word resets to 1", df, 1);

    // R4: zero divisors behave as one
    wr(8'd0, 32'h1);
    repeat (10) @(negedge clk);
    countPulses(40, a, b, f);
    chk("R4 zero divisor is divide-by-one", a, 40);
    chk("R7 out1 gated off", b, 0);

    // R3: source codes
    for (int code = 0; code < 4; code++) begin
      wr(8'd0, (32'(code) << 4) | 32'h1);
      repeat (12) @(negedge clk);
      countPulses(60, a, b, f);
      chk($sformatf("R3 source code %0d", code), a, expSrc[code]);
    end

    // R4: first divisor 5
    wr(8'd0, (32'd5 << 8) | 32'h1);
    repeat (20) @(negedge clk);
    countPulses(100, a, b, f);
    chk("R4 divide by 5", a, 20);

    // R5: cascade 3 x 4
    wr(8'd0, (32'd4 << 20) | (32'd3 << 8) | 32'h1);
    repeat (30) @(negedge clk);
    countPulses(120, a, b, f);
    chk("R5 cascade 3x4", a, 10);

    // R6: external bypass
    wr(8'd0, (32'd7 << 8) | (32'h1 << 6) | 32'h1);
    repeat (30) @(negedge clk);
    pulseQ.delete();
    countPulses(100, a, b, f);
    chk("R6 external bypass count", a, 20);
    // R11: pulse lands in the cycle after the external pulse
    foreach (pulseQ[k]) chk("R11 external pulse alignment", pulseQ[k] % 5, 0);

    // R7: two gates from one divider
    wr(8'd0, (32'd2 << 8) | 32'h3);
    repeat (30) @(negedge clk);
    countPulses(100, a, b, f);
    chk("R7 out0 both gates", a, 50);
    chk("R7 out1 both gates", b, 50);
    wr(8'd0, (32'd2 << 8) | 32'h2);
    repeat (2) @(negedge clk);
    countPulses(100, a, b, f);
    chk("R7 out0 gated off", a, 0);
    chk("R7 out1 still on", b, 50);

    // R9: divisor change mid-period waits for period end
    wr(8'd0, (32'd10 << 8) | 32'h1);
    repeat (30) @(negedge clk);
    pulseQ.delete();
    while (pulseQ.size() == 0) begin @(negedge clk); #2; end
    repeat (3) @(negedge clk);
    wr(8'd0, (32'd2 << 8) | 32'h1);
    repeat (30) @(negedge clk);
    chk("R9 old period completes", pulseQ[1] - pulseQ[0], 10);
    chk("R9 new period afterwards", pulseQ[2] - pulseQ[1], 2);

    // R10: phase survives gating
    wr(8'd0, (32'd4 << 8) | 32'h1);
    repeat (30) @(negedge clk);
    pulseQ.delete();
    repeat (20) @(negedge clk);
    wr(8'd0, (32'd4 << 8));
    repeat (13) @(negedge clk);
    wr(8'd0, (32'd4 << 8) | 32'h1);
    repeat (20) @(negedge clk);
    chk("R10 pulses resumed", pulseQ.size() >= 8, 1);
    foreach (pulseQ[k]) chk("R10 phase kept", (pulseQ[k] - pulseQ[0]) % 4, 0);

    // R8: separate inverted gate word
    wr(8'd0, 32'h1);
    repeat (10) @(negedge clk);
    countPulses(40, a, b, f);
    chk("R8 gate word 1 stops clock", f, 0);
    wr(8'd8, 32'h0);
    repeat (2) @(negedge clk);
    countPulses(40, a, b, f);
    chk("R8 gate word 0 runs clock", f, 40);
    rd(8'd8, dm, df);
    chk("R8 gate word readback", df, 0);
    chk("R2 main reads 0 at offset 8", dm, 0);
    wr(8'd8, 32'h1);
    repeat (2) @(negedge clk);
    countPulses(40, a, b, f);
    chk("R8 gate word stops again", f, 0);

    // R2: readback masking
    wr(8'd0, 32'hFFFF_FFFF);
    rd(8'd0, dm, df);
    chk("R2 two-gate readback", dm, MaskMain);
    chk("R2 separate-gate readback", df, MaskFab);
    wr(8'd0, 32'h0);
    rd(8'd0, dm, df);
    chk("R2 readback cleared", dm, 0);

    done = 1;
    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end

endmodule